// File: doc/BRIEF.md
# Timer interrupt flag and mask unit

This block holds the pending-event flags and the per-source enable bits for a small timer subsystem that has three interrupt sources: an overflow of counter 0, an overflow of counter 1, and a compare match on counter 1's channel A. The timers send it single-cycle event pulses. The CPU reaches both registers over a simple 8-bit register bus with an address, a write strobe, write data and combinational read data.

The unit drives an interrupt request and the vector number to be serviced. A source only raises the request when its flag, its enable bit and the global interrupt enable are all one. The core acknowledges a request by presenting the vector number it is taking. That clears the matching flag. Software can also clear any flag by writing a one to its bit.

Top module: `tmr_irq_ctl`

## Requirements
- R1: After reset both the flag register and the enable register read as 0x00, and `irq` is low.
- R2: The enable register sits at bus address 0x39 and the flag register at 0x38. In both registers bit 6 is the channel-A compare source, bit 2 is the counter 1 overflow source and bit 1 is the counter 0 overflow source. Enable bits are plain read/write storage.
- R3: Bits 7, 5, 4, 3 and 0 of both registers always read zero, and writes to them have no effect. Any other address reads 0x00.
- R4: An event pulse sets its flag, and the flag is visible on the bus in the cycle after the pulse.
- R5: A write to the flag register clears each flag whose data bit is one and leaves a flag unchanged where the data bit is zero.
- R6: An acknowledge clears only the flag whose vector equals `ack_vec`. An acknowledge with any other vector number changes no flag.
- R7: When an event pulse and a clear (by write or by acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R8: `irq` is high only when some source has its flag, its enable bit and `gie` all at one.
- R9: Compare A maps to vector 3, counter 1 overflow to vector 4 and counter 0 overflow to vector 5. When several sources request at once, the lowest vector number is presented.
- R10: An enable bit at zero hides its flag from `irq` but does not clear the flag.
- R11: `irq_vec` is 0 whenever `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ev_ovf0 | input | 1 | Counter 0 overflow pulse |
| ev_ovf1 | input | 1 | Counter 1 overflow pulse |
| ev_cmpa | input | 1 | Counter 1 compare A match pulse |
| gie | input | 1 | Global interrupt enable |
| ack_valid | input | 1 | Vector acknowledge strobe |
| ack_vec | input | 3 | Vector number being acknowledged |
| irq | output | 1 | Interrupt request |
| irq_vec | output | 3 | Vector of the highest-priority request, 0 when none |

## Verification
The bench builds the block with its default parameters: a 6-bit address, a 3-bit vector, registers at 0x38 and 0x39, and vectors 3, 4 and 5. With these values a neighbouring address such as 0x37 can be used to probe decoding. Out-of-range acknowledge codes such as 7 are also within reach, and they must leave every flag alone. The bench drives collisions of events with write-one-to-clear and with acknowledge. It walks the priority order down by acknowledging each vector in turn.

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl #(
  parameter int AW = 6,
  parameter int VW = 3,
  parameter logic [AW-1:0] FLAG_ADDR = 6'h38,
  parameter logic [AW-1:0] MASK_ADDR = 6'h39,
  parameter int BIT_CMPA = 6,
  parameter int BIT_OVF1 = 2,
  parameter int BIT_OVF0 = 1,
  parameter logic [VW-1:0] VEC_CMPA = 3'd3,
  parameter logic [VW-1:0] VEC_OVF1 = 3'd4,
  parameter logic [VW-1:0] VEC_OVF0 = 3'd5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          ev_ovf0,
  input  logic          ev_ovf1,
  input  logic          ev_cmpa,
  input  logic          gie,
  input  logic          ack_valid,
  input  logic [VW-1:0] ack_vec,
  output logic          irq,
  output logic [VW-1:0] irq_vec
);
  // index 0: counter 0 overflow, 1: counter 1 overflow, 2: compare A
  logic [2:0] flg, msk, ev, clr, pend;
  logic       wr_flag, wr_mask;
  logic       unused_wbits;

  assign unused_wbits = ^bus_wdata;
  assign wr_flag = bus_we && (bus_addr == FLAG_ADDR);
  assign wr_mask = bus_we && (bus_addr == MASK_ADDR);
  assign ev = {ev_cmpa, ev_ovf1, ev_ovf0};

  assign clr[0] = (wr_flag && bus_wdata[BIT_OVF0]) || (ack_valid && ack_vec == VEC_OVF0);
  assign clr[1] = (wr_flag && bus_wdata[BIT_OVF1]) || (ack_valid && ack_vec == VEC_OVF1);
  assign clr[2] = (wr_flag && bus_wdata[BIT_CMPA]) || (ack_valid && ack_vec == VEC_CMPA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg <= '0;
      msk <= '0;
    end else begin
      flg <= (flg & ~clr) | ev;
      if (wr_mask) msk <= {bus_wdata[BIT_CMPA], bus_wdata[BIT_OVF1], bus_wdata[BIT_OVF0]};
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == FLAG_ADDR) begin
      bus_rdata[BIT_CMPA] = flg[2];
      bus_rdata[BIT_OVF1] = flg[1];
      bus_rdata[BIT_OVF0] = flg[0];
    end else if (bus_addr == MASK_ADDR) begin
      bus_rdata[BIT_CMPA] = msk[2];
      bus_rdata[BIT_OVF1] = msk[1];
      bus_rdata[BIT_OVF0] = msk[0];
    end
  end

  assign pend = flg & msk & {3{gie}};
  assign irq  = |pend;

  always_comb begin
    if (pend[2])      irq_vec = VEC_CMPA;
    else if (pend[1]) irq_vec = VEC_OVF1;
    else if (pend[0]) irq_vec = VEC_OVF0;
    else              irq_vec = '0;
  end

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n) ev_cmpa |=> flg[2]); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (ev_ovf1 && wr_flag && bus_wdata[BIT_OVF1]) |=> flg[1]); // R7
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (wr_flag && bus_wdata[BIT_CMPA] && !ev_cmpa) |=> !flg[2]); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (ack_valid && ack_vec == VEC_OVF0 && !ev_ovf0) |=> !flg[0]); // R6
  AST_ACK_OTHERS: assert property (@(posedge clk) disable iff (!rst_n) (ack_valid && ack_vec == VEC_OVF0 && !wr_flag && flg[2]) |=> flg[2]); // R6
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> gie); // R8
  AST_TOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n) (gie && flg[2] && msk[2]) |-> irq_vec == VEC_CMPA); // R9
  AST_IDLE_VEC: assert property (@(posedge clk) disable iff (!rst_n) !irq |-> irq_vec == '0); // R11
endmodule

// File: tb/tmr_irq_ctl_tb.sv
module tmr_irq_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_FLAG = 6'h38;
  localparam logic [5:0] A_MASK = 6'h39;

  logic clk = 0, rst_n = 0;
  logic [5:0] bus_addr = A_FLAG;
  logic bus_we = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic ev_ovf0 = 0, ev_ovf1 = 0, ev_cmpa = 0, gie = 0, ack_valid = 0;
  logic [2:0] ack_vec = 0, irq_vec;
  logic irq;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_irq_ctl u_dut (.clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
    .ev_ovf0, .ev_ovf1, .ev_cmpa, .gie, .ack_valid, .ack_vec, .irq, .irq_vec);

  task automatic chk(input int got, input int exp, input string tag);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input int exp, input string tag);
    bus_addr = a; #1; chk(bus_rdata, exp, tag);
  endtask

  task automatic pulse(input logic c, input logic o1, input logic o0);
    @(negedge clk); ev_cmpa = c; ev_ovf1 = o1; ev_ovf0 = o0;
    @(negedge clk); ev_cmpa = 0; ev_ovf1 = 0; ev_ovf0 = 0;
  endtask

  task automatic ack(input logic [2:0] v);
    @(negedge clk); ack_valid = 1; ack_vec = v;
    @(negedge clk); ack_valid = 0;
  endtask

  task automatic t_reset;
    rd_chk(A_FLAG, 0, "R1 flag reset");
    rd_chk(A_MASK, 0, "R1 mask reset");
    chk(irq, 0, "R1 irq reset");
  endtask

  task automatic t_registers;
    wr(A_MASK, 8'hFF); rd_chk(A_MASK, 8'h46, "R2/R3 mask write ff");
    wr(A_MASK, 8'h04); rd_chk(A_MASK, 8'h04, "R2 mask write 04");
    wr(A_MASK, 8'h00); rd_chk(A_MASK, 8'h00, "R2 mask write 00");
    wr(A_FLAG, 8'hFF); rd_chk(A_FLAG, 8'h00, "R3 flag write ff sets nothing");
    rd_chk(6'h37, 0, "R3 unmapped address");
  endtask

  task automatic t_events;
    pulse(0, 0, 1); rd_chk(A_FLAG, 8'h02, "R4 ovf0 sets bit1");
    pulse(0, 1, 0); rd_chk(A_FLAG, 8'h06, "R4 ovf1 sets bit2");
    pulse(1, 0, 0); rd_chk(A_FLAG, 8'h46, "R4 cmpa sets bit6");
  endtask

  task automatic t_w1c;
    wr(A_FLAG, 8'h04); rd_chk(A_FLAG, 8'h42, "R5 w1c bit2");
    wr(A_FLAG, 8'h00); rd_chk(A_FLAG, 8'h42, "R5 write zero keeps");
    wr(A_FLAG, 8'h42); rd_chk(A_FLAG, 8'h00, "R5 w1c bit6 bit1");
  endtask

  task automatic t_gating;
    pulse(1, 1, 1);
    gie = 1; #1;
    chk(irq, 0, "R10 masked no irq");
    rd_chk(A_FLAG, 8'h46, "R10 masked flag kept");
    wr(A_MASK, 8'h02); gie = 0; #1;
    chk(irq, 0, "R8 gie low blocks");
    chk(irq_vec, 0, "R11 idle vec");
    gie = 1; #1;
    chk(irq, 1, "R8 all three high");
    chk(irq_vec, 5, "R9 ovf0 vector 5");
  endtask

  task automatic t_priority;
    wr(A_MASK, 8'h46); #1;
    chk(irq_vec, 3, "R9 cmpa first");
    ack(3'd7); rd_chk(A_FLAG, 8'h46, "R6 foreign ack no effect");
    ack(3'd3); rd_chk(A_FLAG, 8'h06, "R6 ack 3 clears bit6");
    chk(irq_vec, 4, "R9 ovf1 next");
    ack(3'd4); rd_chk(A_FLAG, 8'h02, "R6 ack 4 clears bit2");
    chk(irq_vec, 5, "R9 ovf0 last");
    ack(3'd5); rd_chk(A_FLAG, 8'h00, "R6 ack 5 clears bit1");
    chk(irq, 0, "R8 no request left");
    chk(irq_vec, 0, "R11 vec zero");
  endtask

  task automatic t_race;
    @(negedge clk); ev_ovf1 = 1; bus_addr = A_FLAG; bus_we = 1; bus_wdata = 8'h04;
    @(negedge clk); ev_ovf1 = 0; bus_we = 0;
    rd_chk(A_FLAG, 8'h04, "R7 event beats w1c");
    @(negedge clk); ev_cmpa = 1; ack_valid = 1; ack_vec = 3'd3;
    @(negedge clk); ev_cmpa = 0; ack_valid = 0;
    rd_chk(A_FLAG, 8'h44, "R7 event beats ack");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_registers;
    t_events;
    t_w1c;
    t_gating;
    t_priority;
    t_race;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule